// File: doc/BRIEF.md
# Interrupt Acknowledge Vector Sequencer

This block is the CPU-facing half of a priority interrupt controller. It tracks the processor's two-pulse interrupt-acknowledge handshake. On the first pulse it tells the priority resolver to move the current winner into service, and the data bus stays quiet. On the second pulse it drives the vector byte. The upper bits of that byte come from a programmed base and the low bits carry the level that was latched.

In a cascaded arrangement the same block serves both roles. A slave instance compares its programmed 3-bit identity with the cascade lines and takes part in the handshake only when they match. A master instance holds a per-input map of which inputs are fed by a slave. When such an input wins, the master drives the level on the cascade lines and leaves the data bus to the slave.

The block also handles polling. After a poll command, the next read pulse acts as an acknowledge: the winner is latched and a status byte is returned in place of a vector. Any other read returns the register byte supplied by the command decoder.

Top module: `intack_vec_seq`

## Requirements
- R1: On the first acknowledge pulse, `latch_o` is high combinationally in the cycle where the rising `inta_i` is sampled, with `latch_level_o` = `win_level_i`, provided a request is valid and the instance is addressed. While the first pulse lasts, `data_oe_o` stays 0.
- R2: From the cycle after the rising edge of the second acknowledge pulse is sampled, until the cycle after its falling edge is sampled, the owning instance drives `data_oe_o`=1 and `data_o` = {`vec_base_i`, latched level}. The latched level is held even if `win_level_i` changes between the two pulses.
- R3: If no valid request is present at the first pulse, `latch_o` stays 0 and the vector carries level 7 (all ones).
- R4: When `is_slave_i`=1, the instance latches and drives its vector only when `cas_i` equals `cas_id_i`. Otherwise both `latch_o` and `data_oe_o` stay 0 for the whole handshake.
- R5: When `is_slave_i`=0 and bit L of `slave_map_i` is set for the winning level L, the master:
  - drives `cas_o`=L with `cas_oe_o`=1 from the cycle after the first pulse is sampled until after the second pulse ends;
  - keeps `data_oe_o`=0 during the second pulse.
- R6: A one-cycle `poll_cmd_i` arms a poll. The next read pulse asserts `latch_o` (if a request is valid) and returns a status byte with:
  - bit 7 = request present;
  - bits 6..3 = 0;
  - bits 2..0 = the pending level, or 0 when there is none.
- R7: The poll clears itself after the single read it applies to. The following read returns `reg_data_i` and does not assert `latch_o`.
- R8: `data_oe_o` is 1 only during an owned second acknowledge pulse, a poll read, or a register read. A register read drives `data_o` = `reg_data_i`. Out of reset all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | clock |
| rst_ni | input | 1 | asynchronous reset, active low |
| inta_i | input | 1 | acknowledge strobe from the CPU, high during a pulse |
| rd_i | input | 1 | read strobe, high during a pulse |
| poll_cmd_i | input | 1 | one-cycle pulse: a poll command was written |
| win_valid_i | input | 1 | the resolver has an unmasked winner |
| win_level_i | input | 3 | level of the winner |
| latch_o | output | 1 | strobe to the resolver: set the in-service bit for `latch_level_o` |
| latch_level_o | output | 3 | level to place in service |
| is_slave_i | input | 1 | instance is configured as a slave |
| cas_id_i | input | 3 | programmed slave identity |
| cas_i | input | 3 | cascade lines seen by a slave |
| slave_map_i | input | 8 | master: bit L set means input L is fed by a slave |
| cas_o | output | 3 | cascade lines driven by a master |
| cas_oe_o | output | 1 | cascade line enable |
| vec_base_i | input | 5 | programmed upper vector bits |
| reg_data_i | input | 8 | register byte for ordinary reads |
| data_o | output | 8 | CPU data byte |
| data_oe_o | output | 1 | data bus drive enable |

## Verification
The hardest situation to reach is a second acknowledge pulse whose owner was decided one pulse earlier. That owner can be the master, a slave that matched the cascade lines, or nobody. The stimulus sweeps every level, with and without a valid request, on a master whose map marks input 2 as cascaded. It then sweeps all eight cascade values against a slave of identity 2. Between the pulses the winner inputs are deliberately changed, so that a vector built from live inputs rather than the latched level would show.

// File: rtl/intack_pkg.sv
package intack_pkg;
  typedef enum logic [1:0] {ACK_IDLE, ACK_FIRST, ACK_GAP, ACK_SECOND} ack_phase_e;
  typedef enum logic [1:0] {RD_NONE, RD_POLL, RD_REG} rd_mode_e;
endpackage

// File: rtl/intack_edge.sv
module intack_edge (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic lvl_i,
  output logic rise_o,
  output logic fall_o
);
  logic q;
  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) q <= 1'b0;
    else         q <= lvl_i;
  assign rise_o = lvl_i & ~q;
  assign fall_o = ~lvl_i & q;
endmodule

// File: rtl/intack_ack_fsm.sv
module intack_ack_fsm
  import intack_pkg::*;
#(
  parameter int LVL_W = 3,
  localparam int N_LVL = 1 << LVL_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             rise_i,
  input  logic             fall_i,
  input  logic             addr_i,
  input  logic             is_slave_i,
  input  logic             win_valid_i,
  input  logic [LVL_W-1:0] win_level_i,
  input  logic [N_LVL-1:0] slave_map_i,
  output logic             take_o,
  output ack_phase_e       phase_o,
  output logic [LVL_W-1:0] level_o,
  output logic             own_o,
  output logic             casc_o
);
  ack_phase_e       phase_q;
  logic [LVL_W-1:0] lvl_q;
  logic             own_q, casc_q, casc_d;

  assign casc_d = ~is_slave_i & win_valid_i & slave_map_i[win_level_i];
  assign take_o = rise_i & (phase_q == ACK_IDLE) & addr_i & win_valid_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= ACK_IDLE;
      lvl_q   <= '0;
      own_q   <= 1'b0;
      casc_q  <= 1'b0;
    end else begin
      unique case (phase_q)
        ACK_IDLE: if (rise_i) begin
          phase_q <= ACK_FIRST;
          lvl_q   <= win_valid_i ? win_level_i : {LVL_W{1'b1}}; // spurious -> lowest level
          casc_q  <= casc_d;
          own_q   <= addr_i & ~casc_d;
        end
        ACK_FIRST:  if (fall_i) phase_q <= ACK_GAP;
        ACK_GAP:    if (rise_i) phase_q <= ACK_SECOND;
        ACK_SECOND: if (fall_i) begin
          phase_q <= ACK_IDLE;
          own_q   <= 1'b0;
          casc_q  <= 1'b0;
        end
        default: phase_q <= ACK_IDLE;
      endcase
    end
  end

  assign phase_o = phase_q;
  assign level_o = lvl_q;
  assign own_o   = own_q;
  assign casc_o  = casc_q;
endmodule

// File: rtl/intack_poll_unit.sv
module intack_poll_unit
  import intack_pkg::*;
#(
  parameter int LVL_W  = 3,
  parameter int DATA_W = 8,
  localparam int PAD_W = DATA_W - 1 - LVL_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              poll_cmd_i,
  input  logic              rise_i,
  input  logic              fall_i,
  input  logic              win_valid_i,
  input  logic [LVL_W-1:0]  win_level_i,
  output logic              take_o,
  output logic              armed_o,
  output rd_mode_e          mode_o,
  output logic [DATA_W-1:0] status_o
);
  logic              armed_q;
  rd_mode_e          mode_q;
  logic [DATA_W-1:0] stat_q;

  assign take_o = rise_i & armed_q & win_valid_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      armed_q <= 1'b0;
      mode_q  <= RD_NONE;
      stat_q  <= '0;
    end else begin
      if (rise_i)     armed_q <= 1'b0;
      if (poll_cmd_i) armed_q <= 1'b1;
      if (mode_q == RD_NONE) begin
        if (rise_i) begin
          mode_q <= armed_q ? RD_POLL : RD_REG;
          stat_q <= {win_valid_i, {PAD_W{1'b0}},
                     win_valid_i ? win_level_i : {LVL_W{1'b0}}};
        end
      end else if (fall_i) begin
        mode_q <= RD_NONE;
      end
    end
  end

  assign armed_o  = armed_q;
  assign mode_o   = mode_q;
  assign status_o = stat_q;
endmodule

// File: rtl/intack_vec_seq.sv
module intack_vec_seq
  import intack_pkg::*;
#(
  parameter int LVL_W  = 3,
  parameter int DATA_W = 8,
  localparam int N_LVL  = 1 << LVL_W,
  localparam int BASE_W = DATA_W - LVL_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              inta_i,
  input  logic              rd_i,
  input  logic              poll_cmd_i,
  input  logic              win_valid_i,
  input  logic [LVL_W-1:0]  win_level_i,
  output logic              latch_o,
  output logic [LVL_W-1:0]  latch_level_o,
  input  logic              is_slave_i,
  input  logic [LVL_W-1:0]  cas_id_i,
  input  logic [LVL_W-1:0]  cas_i,
  input  logic [N_LVL-1:0]  slave_map_i,
  output logic [LVL_W-1:0]  cas_o,
  output logic              cas_oe_o,
  input  logic [BASE_W-1:0] vec_base_i,
  input  logic [DATA_W-1:0] reg_data_i,
  output logic [DATA_W-1:0] data_o,
  output logic              data_oe_o
);
  logic              ack_rise, ack_fall, rd_rise, rd_fall;
  logic              addr, ack_take, poll_take, own, casc, poll_armed;
  logic [LVL_W-1:0]  ack_level;
  logic [DATA_W-1:0] poll_status;
  ack_phase_e        ack_phase;
  rd_mode_e          rd_mode;

  intack_edge u_ack_edge (.clk_i, .rst_ni, .lvl_i(inta_i), .rise_o(ack_rise), .fall_o(ack_fall));
  intack_edge u_rd_edge  (.clk_i, .rst_ni, .lvl_i(rd_i),   .rise_o(rd_rise),  .fall_o(rd_fall));

  assign addr = ~is_slave_i | (cas_i == cas_id_i);

  intack_ack_fsm #(.LVL_W(LVL_W)) u_ack (
    .clk_i, .rst_ni, .rise_i(ack_rise), .fall_i(ack_fall), .addr_i(addr),
    .is_slave_i, .win_valid_i, .win_level_i, .slave_map_i,
    .take_o(ack_take), .phase_o(ack_phase), .level_o(ack_level),
    .own_o(own), .casc_o(casc)
  );

  intack_poll_unit #(.LVL_W(LVL_W), .DATA_W(DATA_W)) u_poll (
    .clk_i, .rst_ni, .poll_cmd_i, .rise_i(rd_rise), .fall_i(rd_fall),
    .win_valid_i, .win_level_i, .take_o(poll_take), .armed_o(poll_armed),
    .mode_o(rd_mode), .status_o(poll_status)
  );

  assign latch_o       = ack_take | poll_take;
  assign latch_level_o = win_level_i;
  assign cas_o         = casc ? ack_level : '0;
  assign cas_oe_o      = casc;

  always_comb begin
    data_oe_o = 1'b1;
    unique case (rd_mode)
      RD_POLL: data_o = poll_status;
      RD_REG:  data_o = reg_data_i;
      default: begin
        data_o    = {vec_base_i, ack_level};
        data_oe_o = (ack_phase == ACK_SECOND) & own;
        if (!data_oe_o) data_o = '0;
      end
    endcase
  end
endmodule

// File: rtl/intack_vec_seq_chk.sv
module intack_vec_seq_chk
  import intack_pkg::*;
#(
  parameter int LVL_W  = 3,
  parameter int DATA_W = 8,
  localparam int BASE_W = DATA_W - LVL_W
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              win_valid_i,
  input logic              poll_cmd_i,
  input logic              latch_o,
  input logic              cas_oe_o,
  input logic [BASE_W-1:0] vec_base_i,
  input logic [DATA_W-1:0] data_o,
  input logic              data_oe_o,
  input ack_phase_e        phase,
  input rd_mode_e          mode,
  input logic              own,
  input logic              armed,
  input logic              rd_rise
);
  // R1
  first_pulse_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase == ACK_FIRST && mode == RD_NONE) |-> !data_oe_o);
  // R1
  latch_needs_req_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    latch_o |-> win_valid_i);
  // R2
  vec_base_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase == ACK_SECOND && own && mode == RD_NONE) |-> (data_oe_o && data_o[DATA_W-1:LVL_W] == vec_base_i));
  // R5
  casc_no_data_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cas_oe_o && mode == RD_NONE) |-> !data_oe_o);
  // R6
  poll_status_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode == RD_POLL) |-> (data_oe_o && data_o[DATA_W-2:LVL_W] == '0));
  // R7
  poll_once_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (armed && rd_rise && !poll_cmd_i) |=> !armed);
endmodule

bind intack_vec_seq intack_vec_seq_chk #(.LVL_W(LVL_W), .DATA_W(DATA_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .win_valid_i(win_valid_i), .poll_cmd_i(poll_cmd_i),
  .latch_o(latch_o), .cas_oe_o(cas_oe_o), .vec_base_i(vec_base_i), .data_o(data_o),
  .data_oe_o(data_oe_o), .phase(ack_phase), .mode(rd_mode), .own(own),
  .armed(poll_armed), .rd_rise(rd_rise)
);

// File: tb/sim_intack_vec_seq.sv
module sim_intack_vec_seq;
  logic       clk = 1'b0, rst_n = 1'b0;
  logic       inta = 0, rd = 0, poll_cmd = 0, win_valid = 0, is_slave = 0;
  logic [2:0] win_level = 0, cas_id = 3'd2, cas_in = 0;
  logic [7:0] slave_map = 8'h04, reg_data = 8'h5A;
  logic [4:0] vec_base = 5'b10110;
  logic       latch, cas_oe, data_oe;
  logic [2:0] latch_level, cas_out;
  logic [7:0] data;
  int checks = 0, fails = 0;
  bit done = 0;

  always #5 clk = ~clk;

  intack_vec_seq u0 (
    .clk_i(clk), .rst_ni(rst_n), .inta_i(inta), .rd_i(rd), .poll_cmd_i(poll_cmd),
    .win_valid_i(win_valid), .win_level_i(win_level), .latch_o(latch),
    .latch_level_o(latch_level), .is_slave_i(is_slave), .cas_id_i(cas_id),
    .cas_i(cas_in), .slave_map_i(slave_map), .cas_o(cas_out), .cas_oe_o(cas_oe),
    .vec_base_i(vec_base), .reg_data_i(reg_data), .data_o(data), .data_oe_o(data_oe)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // full two-pulse handshake; expectations computed from the requirements
  task automatic ack_seq(input bit v, input int lvl, input bit exp_addr);
    bit casc     = !is_slave && v && slave_map[lvl];
    bit exp_take = v && exp_addr;
    bit exp_oe   = exp_addr && !casc;
    int exp_lvl  = v ? lvl : 7;
    int exp_data = 32'hB0 + exp_lvl;
    win_valid = v; win_level = lvl[2:0]; inta = 1;
    #1;
    chk(latch == exp_take, "R1/R3/R4 latch", latch, exp_take);
    if (exp_take) chk(latch_level == lvl[2:0], "R1 latch level", latch_level, lvl);
    @(negedge clk);
    chk(data_oe == 0, "R1 first pulse quiet", data_oe, 0);
    chk(cas_oe == casc, "R5 cas enable", cas_oe, casc);
    if (casc) chk(cas_out == lvl[2:0], "R5 cas level", cas_out, lvl);
    win_level = ~lvl[2:0]; win_valid = !v;
    inta = 0;
    repeat (2) @(negedge clk);
    inta = 1;
    @(negedge clk);
    chk(data_oe == exp_oe, "R2/R4/R5 second pulse oe", data_oe, exp_oe);
    if (exp_oe) chk(data == exp_data[7:0], "R2/R3 vector", data, exp_data);
    chk(latch == 0, "R1 no latch on second pulse", latch, 0);
    @(negedge clk);
    chk(data_oe == exp_oe, "R2 oe held", data_oe, exp_oe);
    inta = 0;
    @(negedge clk);
    chk(data_oe == 0, "R8 oe released", data_oe, 0);
    chk(cas_oe == 0, "R5 cas released", cas_oe, 0);
    @(negedge clk);
  endtask

  task automatic read_seq(input bit exp_poll, input bit v, input int lvl);
    int exp_data = exp_poll ? (v ? 128 + lvl : 0) : int'(reg_data);
    win_valid = v; win_level = lvl[2:0]; rd = 1;
    #1;
    chk(latch == (exp_poll && v), exp_poll ? "R6 poll latch" : "R7 no latch on plain read",
        latch, exp_poll && v);
    @(negedge clk);
    win_level = ~lvl[2:0];
    @(negedge clk);
    chk(data_oe == 1, "R6/R8 read oe", data_oe, 1);
    chk(data == exp_data[7:0], exp_poll ? "R6 status byte" : "R7/R8 reg byte", data, exp_data);
    rd = 0;
    @(negedge clk);
    chk(data_oe == 0, "R8 read oe released", data_oe, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(data_oe == 0 && latch == 0 && cas_oe == 0 && data == 0, "R8 reset state",
        {data_oe, latch, cas_oe}, 0);
    rst_n = 1;
    @(negedge clk);
    // master sweep, input 2 cascaded
    for (int v = 0; v < 2; v++)
      for (int l = 0; l < 8; l++) ack_seq(v[0], l, 1'b1);
    // slave sweep over cascade values, identity 2
    is_slave = 1;
    for (int c = 0; c < 8; c++) begin
      cas_in = c[2:0];
      ack_seq(1'b1, 5, c == 2);
    end
    is_slave = 0;
    // poll sweep, each followed by a plain read
    for (int v = 0; v < 2; v++)
      for (int l = 0; l < 8; l++) begin
        reg_data = 8'h30 + 8'(l);
        poll_cmd = 1; @(negedge clk); poll_cmd = 0;
        read_seq(1'b1, v[0], l);
        read_seq(1'b0, 1'b1, l);
      end
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule